// File: doc/BRIEF.md
# DRAM strobe cycle decoder

This block sits at the pin side of an asynchronous dynamic memory and turns the row strobe, the two byte-lane column strobes, the write strobe and the output-enable strobe into synchronous control for a memory array. A fast local clock samples all five pins through a two-stage synchronizer. Edges are taken from the synchronized values. The order in which the edges arrive decides what kind of memory cycle is in progress: a plain access, a read-modify-write, a refresh at an externally supplied row, a refresh that uses an internal row counter, a hidden refresh, or self-refresh.

The outputs are single-cycle pulses telling the array when to capture the row and the column address. Further outputs are a per-lane write pulse, per-lane output-drive enables that follow extended-data-out rules, and a refresh pulse that carries the row taken from the internal counter. A held refresh condition moves the block into self-refresh. In that state an internal timer issues periodic counter refreshes until the row strobe returns high. Once per row-strobe cycle, a cycle-type code is published when the row strobe rises.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset `cycle_type` is 0 (standby) and `dout_en` is 0; whenever the row strobe and both column strobes are inactive (high), `dout_en` returns to 0.
- R2: A column strobe that falls while the row strobe is high, followed by the row strobe falling, produces one `refresh_go` pulse with `refresh_row` equal to the internal counter. The counter starts at 0 and advances by one after each refresh. At the row strobe rise, `cycle_type` becomes 5.
- R3: A row strobe fall with both column strobes high pulses `row_latch` once. If no column strobe falls before the row strobe rises, `cycle_type` becomes 4 and no `refresh_go` is issued.
- R4: If the row strobe rises and falls again while a column strobe stays low from an access, the result is a counter refresh (`refresh_go`, next counter row) with `cycle_type` 6 at the following rise, and `dout_en` keeps driving the read lanes throughout.
- R5: A write-strobe fall while a column strobe is low in an access whose column was opened for reading pulses `byte_we` for the lanes whose strobe is low (bit 0 lower lane, bit 1 upper lane). `dout_en` drops to 0, and `cycle_type` becomes 3.
- R6: A column strobe falling while the write strobe is low pulses `byte_we` only for the lanes whose strobe is low, and `cycle_type` becomes 2. In page mode each column strobe fall writes again.
- R7: After a read column strobe, `dout_en` drives the opened lanes and keeps driving after the column strobes rise while the row and output-enable strobes are low and the write strobe is high. It is 0 whenever the output-enable strobe is high or the write strobe is low.
- R8: When the row and a column strobe stay low in a counter refresh for `SELF_TICKS` clocks, `self_ref` rises. While in self-refresh, a counter `refresh_go` occurs every `REF_TICKS` clocks. `self_ref` clears at the row strobe rise, and `cycle_type` becomes 7.
- R9: `col_latch` pulses once at the first falling column strobe of either lane, not again for the second lane. A row cycle with column strobes but no write reports `cycle_type` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe pin, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| row_latch | output | 1 | Pulse: capture the row address |
| col_latch | output | 1 | Pulse: capture the column address |
| byte_we | output | 2 | Per-lane write pulse, bit 0 lower |
| dout_en | output | 2 | Per-lane output drive enable |
| refresh_go | output | 1 | Pulse: refresh the row on `refresh_row` |
| refresh_row | output | ROW_W | Counter row for the refresh |
| self_ref | output | 1 | Self-refresh active |
| cycle_valid | output | 1 | Pulse: `cycle_type` updated |
| cycle_type | output | 3 | 0 standby, 1 read, 2 write, 3 read-modify-write, 4 row-only refresh, 5 column-first refresh, 6 hidden, 7 self |

## Verification
The bench builds the block with `SELF_TICKS` = 40 and `REF_TICKS` = 16 instead of the 100 µs-scale defaults. With these values, entry into self-refresh and several periodic internal refreshes happen within a few hundred clocks. This puts the counter sequence across column-first, hidden and self-timed refreshes, and the exit on the row strobe rise, within one short run. `ROW_W` stays at 10.

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ROW_W      = 10,
  parameter int SELF_TICKS = 20000,
  parameter int REF_TICKS  = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             ucas_n,
  input  logic             lcas_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic             row_latch,
  output logic             col_latch,
  output logic [1:0]       byte_we,
  output logic [1:0]       dout_en,
  output logic             refresh_go,
  output logic [ROW_W-1:0] refresh_row,
  output logic             self_ref,
  output logic             cycle_valid,
  output logic [2:0]       cycle_type
);
  localparam int STW = $clog2(SELF_TICKS + 1);
  localparam int RTW = $clog2(REF_TICKS + 1);
  localparam logic [2:0] T_RD = 3'd1, T_WR = 3'd2, T_RMW = 3'd3, T_RONLY = 3'd4,
                         T_CBR = 3'd5, T_HID = 3'd6, T_SELF = 3'd7;

  typedef enum logic [1:0] {M_IDLE, M_ACCESS, M_REFR} mode_t;

  logic [4:0] sy1, sy2, prv;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; prv <= '0;
    end else begin
      sy1 <= {~oe_n, ~we_n, ~ucas_n, ~lcas_n, ~ras_n};
      sy2 <= sy1;
      prv <= sy2;
    end

  logic       ras, cas, we, oe;
  logic [1:0] lanes, lane_fall;
  logic       ras_fall, ras_rise, cas_first, we_fall;
  assign ras       = sy2[0];
  assign lanes     = sy2[2:1];
  assign we        = sy2[3];
  assign oe        = sy2[4];
  assign cas       = |lanes;
  assign ras_fall  = ras & ~prv[0];
  assign ras_rise  = ~ras & prv[0];
  assign lane_fall = lanes & ~prv[2:1];
  assign cas_first = cas & ~|prv[2:1];
  assign we_fall   = we & ~prv[3];

  mode_t            mode;
  logic             hidden_q, cas_held, col_seen, wr_seen, rmw_seen;
  logic [ROW_W-1:0] rcnt;
  logic [STW-1:0]   st_cnt;
  logic [RTW-1:0]   rt_cnt;
  logic [1:0]       drv, drv_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cas_held <= 1'b0;
    else if (!cas)             cas_held <= 1'b0;
    else if (cas_first && ras) cas_held <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= M_IDLE; hidden_q <= 1'b0; col_seen <= 1'b0; wr_seen <= 1'b0;
      rmw_seen <= 1'b0; rcnt <= '0; st_cnt <= '0; rt_cnt <= '0;
      row_latch <= 1'b0; col_latch <= 1'b0; byte_we <= '0; refresh_go <= 1'b0;
      refresh_row <= '0; self_ref <= 1'b0; cycle_valid <= 1'b0; cycle_type <= '0;
    end else begin
      row_latch   <= 1'b0;
      col_latch   <= 1'b0;
      byte_we     <= '0;
      refresh_go  <= 1'b0;
      cycle_valid <= 1'b0;
      if (ras_fall) begin
        if (cas) begin
          mode        <= M_REFR;
          hidden_q    <= cas_held;
          refresh_go  <= 1'b1;
          refresh_row <= rcnt;
          rcnt        <= rcnt + 1'b1;
          st_cnt      <= '0;
        end else begin
          mode      <= M_ACCESS;
          row_latch <= 1'b1;
          col_seen  <= 1'b0;
          wr_seen   <= 1'b0;
          rmw_seen  <= 1'b0;
        end
      end else if (ras_rise) begin
        cycle_valid <= 1'b1;
        if (mode == M_REFR)
          cycle_type <= self_ref ? T_SELF : (hidden_q ? T_HID : T_CBR);
        else
          cycle_type <= rmw_seen ? T_RMW : wr_seen ? T_WR : col_seen ? T_RD : T_RONLY;
        mode     <= M_IDLE;
        self_ref <= 1'b0;
      end else if (mode == M_ACCESS) begin
        if (cas_first) begin
          col_latch <= 1'b1;
          col_seen  <= 1'b1;
        end
        byte_we <= (lane_fall & {2{we}}) | (lanes & {2{we_fall}});
        if (|lane_fall && we) wr_seen  <= 1'b1;
        if (we_fall && cas)   rmw_seen <= 1'b1;
      end else if (mode == M_REFR) begin
        if (!self_ref) begin
          if (!cas) st_cnt <= '0;
          else if (32'(st_cnt) == SELF_TICKS - 1) begin
            self_ref <= 1'b1;
            rt_cnt   <= '0;
          end else st_cnt <= st_cnt + 1'b1;
        end else if (32'(rt_cnt) == REF_TICKS - 1) begin
          rt_cnt      <= '0;
          refresh_go  <= 1'b1;
          refresh_row <= rcnt;
          rcnt        <= rcnt + 1'b1;
        end else rt_cnt <= rt_cnt + 1'b1;
      end
    end

  always_comb begin
    drv_nxt = drv;
    if ((!ras && !cas) || we)        drv_nxt = '0;
    else if (mode == M_ACCESS && ras) drv_nxt = cas_first ? lanes : (drv | lane_fall);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      drv <= '0; dout_en <= '0;
    end else begin
      drv     <= drv_nxt;
      dout_en <= drv_nxt & {2{oe & ~we}};
    end
endmodule

module dram_cycle_decoder_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras,
  input logic             cas,
  input logic [1:0]       lanes,
  input logic             we,
  input logic             oe,
  input logic [1:0]       dout_en,
  input logic [1:0]       byte_we,
  input logic             refresh_go,
  input logic [ROW_W-1:0] refresh_row,
  input logic             self_ref,
  input logic             row_latch
);
  logic             seen;
  logic [ROW_W-1:0] last_row;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen <= 1'b0; last_row <= '0;
    end else if (refresh_go) begin
      seen <= 1'b1; last_row <= refresh_row;
    end

  a_r1_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras && !cas) |=> dout_en == 2'b00);
  a_r7_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe || we) |=> dout_en == 2'b00);
  a_r6_lane_write: assert property (@(posedge clk) disable iff (!rst_n)
    |byte_we |-> (byte_we & ~$past(lanes)) == 2'b00);
  a_r2_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_go && seen) |-> refresh_row == last_row + 1'b1);
  a_r8_self_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (self_ref && !ras) |=> !self_ref);
  a_r3_row_or_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_latch && refresh_go));
endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras(ras), .cas(cas), .lanes(lanes), .we(we), .oe(oe),
  .dout_en(dout_en), .byte_we(byte_we), .refresh_go(refresh_go),
  .refresh_row(refresh_row), .self_ref(self_ref), .row_latch(row_latch));

// File: tb/dram_cycle_decoder_bench.sv
module dram_cycle_decoder_bench;
  localparam int ROW_W = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic row_latch, col_latch, refresh_go, self_ref, cycle_valid;
  logic [1:0] byte_we, dout_en;
  logic [ROW_W-1:0] refresh_row;
  logic [2:0] cycle_type;

  always #2.5 clk = ~clk;

  dram_cycle_decoder #(.ROW_W(ROW_W), .SELF_TICKS(40), .REF_TICKS(16)) u_dram_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .row_latch(row_latch), .col_latch(col_latch),
    .byte_we(byte_we), .dout_en(dout_en), .refresh_go(refresh_go),
    .refresh_row(refresh_row), .self_ref(self_ref), .cycle_valid(cycle_valid),
    .cycle_type(cycle_type));

  int checks = 0, errors = 0;
  int rl_cnt = 0, cl_cnt = 0, ref_cnt = 0, self_refs = 0;
  int exp_row = 0;
  bit done = 0;
  logic [2:0] q_type[$];
  logic [1:0] q_we[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pins(input logic r, input logic u, input logic l, input logic w, input logic o);
    ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o;
    wait_cyc(5);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (cycle_valid) begin
      if (q_type.size() == 0) chk(1'b0, "R1 unexpected cycle", int'(cycle_type), -1);
      else begin
        logic [2:0] e;
        e = q_type.pop_front();
        chk(cycle_type == e, "R9 cycle type", int'(cycle_type), int'(e));
      end
    end
    if (refresh_go) begin
      chk(int'(refresh_row) == exp_row, "R2 refresh row", int'(refresh_row), exp_row);
      exp_row++;
      ref_cnt++;
      if (self_ref) self_refs++;
    end
    if (|byte_we) begin
      if (q_we.size() == 0) chk(1'b0, "R6 unexpected write", int'(byte_we), 0);
      else begin
        logic [1:0] e;
        e = q_we.pop_front();
        chk(byte_we == e, "R6 lane write", int'(byte_we), int'(e));
      end
    end
    if (row_latch) rl_cnt++;
    if (col_latch) cl_cnt++;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    chk(cycle_type == 3'd0, "R1 reset type", int'(cycle_type), 0);
    chk(dout_en == 2'b00, "R1 reset dout", int'(dout_en), 0);
    chk(!self_ref, "R8 reset self", int'(self_ref), 0);

    // R9/R7: word read with EDO hold
    q_type.push_back(3'd1);
    pins(0, 1, 1, 1, 0);
    pins(0, 0, 0, 1, 0);
    chk(dout_en == 2'b11, "R7 read drive", int'(dout_en), 3);
    pins(0, 1, 1, 1, 0);
    chk(dout_en == 2'b11, "R7 EDO hold", int'(dout_en), 3);
    pins(0, 1, 1, 1, 1);
    chk(dout_en == 2'b00, "R7 oe off", int'(dout_en), 0);
    pins(1, 1, 1, 1, 0);
    chk(dout_en == 2'b00, "R1 standby hiz", int'(dout_en), 0);

    // R6: lower lane early write
    q_type.push_back(3'd2); q_we.push_back(2'b01);
    pins(0, 1, 1, 0, 0);
    pins(0, 1, 0, 0, 0);
    chk(dout_en == 2'b00, "R7 write no drive", int'(dout_en), 0);
    pins(1, 1, 1, 1, 0);

    // R5: upper lane read-modify-write
    q_type.push_back(3'd3); q_we.push_back(2'b10);
    pins(0, 1, 1, 1, 0);
    pins(0, 0, 1, 1, 0);
    chk(dout_en == 2'b10, "R5 read phase", int'(dout_en), 2);
    pins(0, 0, 1, 0, 0);
    chk(dout_en == 2'b00, "R5 write phase", int'(dout_en), 0);
    pins(1, 1, 1, 1, 0);

    // R6: page-mode writes
    q_type.push_back(3'd2);
    q_we.push_back(2'b11); q_we.push_back(2'b10); q_we.push_back(2'b11);
    pins(0, 1, 1, 0, 0);
    pins(0, 0, 0, 0, 0); pins(0, 1, 1, 0, 0);
    pins(0, 0, 1, 0, 0); pins(0, 1, 1, 0, 0);
    pins(0, 0, 0, 0, 0); pins(0, 1, 1, 0, 0);
    pins(1, 1, 1, 1, 0);

    // R3: row-only refresh
    q_type.push_back(3'd4);
    pins(0, 1, 1, 1, 0);
    pins(1, 1, 1, 1, 0);
    chk(ref_cnt == 0, "R3 no counter refresh", ref_cnt, 0);

    // R2: two column-first refreshes
    q_type.push_back(3'd5); q_type.push_back(3'd5);
    for (int k = 0; k < 2; k++) begin
      pins(1, 0, 0, 1, 0);
      pins(0, 0, 0, 1, 0);
      pins(0, 1, 1, 1, 0);
      pins(1, 1, 1, 1, 0);
    end
    chk(ref_cnt == 2, "R2 refresh count", ref_cnt, 2);

    // R4: hidden refresh after a read
    q_type.push_back(3'd1); q_type.push_back(3'd6);
    pins(0, 1, 1, 1, 0);
    pins(0, 0, 0, 1, 0);
    pins(1, 0, 0, 1, 0);
    chk(dout_en == 2'b11, "R4 hold across rise", int'(dout_en), 3);
    pins(0, 0, 0, 1, 0);
    chk(dout_en == 2'b11, "R4 hold in refresh", int'(dout_en), 3);
    chk(ref_cnt == 3, "R4 counter refresh", ref_cnt, 3);
    pins(1, 0, 0, 1, 0);
    pins(1, 1, 1, 1, 0);
    chk(dout_en == 2'b00, "R1 release hiz", int'(dout_en), 0);

    // R8: self-refresh
    q_type.push_back(3'd7);
    pins(1, 0, 0, 1, 0);
    pins(0, 0, 0, 1, 0);
    chk(!self_ref, "R8 not yet self", int'(self_ref), 0);
    wait_cyc(110);
    chk(self_ref, "R8 self entered", int'(self_ref), 1);
    chk(self_refs >= 2, "R8 periodic refresh", self_refs, 2);
    pins(1, 0, 0, 1, 0);
    chk(!self_ref, "R8 self exit", int'(self_ref), 0);
    pins(1, 1, 1, 1, 0);

    wait_cyc(5);
    chk(rl_cnt == 6, "R3 row latches", rl_cnt, 6);
    chk(cl_cnt == 7, "R9 column latches", cl_cnt, 7);
    chk(q_type.size() == 0, "R9 pending types", q_type.size(), 0);
    chk(q_we.size() == 0, "R6 pending writes", q_we.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule